// File: doc/BRIEF.md
# Egress Multi-Queue Priority Scheduler

This block is the transmit scheduler for one egress port. Descriptors arrive with a 2-bit priority and are placed in one of up to four FIFOs. A configuration word selects how many FIFOs are in use: one, two or four. The MAC takes the next descriptor whenever it raises its ready signal. The scheduler decides which FIFO supplies that descriptor.

There are two service disciplines. In strict mode, the highest-numbered non-empty FIFO always wins. In weighted mode, each FIFO holds a per-round credit that is loaded from a 7-bit weight. A FIFO keeps the grant until its credit runs out or it empties, and the grant then passes downward.

In two-FIFO mode, a 2-bit threshold decides which priority levels count as high. Configuration is sampled only while every FIFO is empty, so a mode change never reorders descriptors that are already waiting.

Top module: `egress_prio_sched`

## Requirements
- R1: After reset all FIFOs are empty: `deq_valid` is 0, `q_full` is 0 and `drop_count` is 0.
- R2: With `cfg_qmode` 00 or 11, every descriptor enters FIFO 0 and leaves in arrival order whatever its priority. `deq_queue` then reads 0.
- R3: `deq_valid` is high in every cycle in which any FIFO holds an entry, and `deq_desc` shows the head of the granted FIFO. The entry is removed at the rising edge where `deq_valid` and `deq_ready` are both high. An entry accepted at an edge is visible at the output right after that edge.
- R4: With `cfg_qmode` 10, a descriptor of priority p enters FIFO p. `deq_queue` reports the FIFO that supplies `deq_desc`.
- R5: With `cfg_weighted` 0, the grant goes to the highest-numbered non-empty FIFO (3 is the highest, 0 the lowest). Within a FIFO, entries leave in arrival order.
- R6: With `cfg_qmode` 01, priority p enters FIFO 1 when p is greater than `cfg_fold` and FIFO 0 otherwise. So `cfg_fold` 11 sends every priority to FIFO 0.
- R7: With `cfg_weighted` 1, the weight of FIFO i sits in `cfg_weights[7i+6:7i]`.
  - The grant goes to the highest non-empty FIFO that still has credit.
  - Each grant spends one credit.
  - When no non-empty FIFO has credit left, every credit is reloaded from its weight, in the same cycle as that grant.
- R8: A weight of 0 is treated as 1.
- R9: All credits are cleared in any cycle where every FIFO is empty, so each busy period starts with a fresh round.
- R10: `q_full[i]` is high while FIFO i holds DEPTH entries.
  - An enqueue aimed at a full FIFO is discarded and raises `drop_count` by one (wrapping).
  - A grant in the same cycle does not make room for it.
- R11: `cfg_qmode`, `cfg_weighted`, `cfg_fold` and `cfg_weights` are captured only at edges where all FIFOs are empty. Waiting entries, and those enqueued before the FIFOs drain, follow the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_qmode | input | 2 | FIFO layout: 00/11 one, 01 two, 10 four |
| cfg_weighted | input | 1 | 1 selects weighted service, 0 strict |
| cfg_fold | input | 2 | Two-FIFO threshold: priorities above it are high |
| cfg_weights | input | 28 | Four 7-bit weights, FIFO i at bits 7i+6:7i |
| enq_valid | input | 1 | Enqueue strobe |
| enq_desc | input | DESC_W | Descriptor to enqueue |
| enq_prio | input | 2 | Priority of the descriptor |
| deq_ready | input | 1 | MAC takes the offered descriptor |
| deq_valid | output | 1 | A descriptor is offered |
| deq_desc | output | DESC_W | Offered descriptor |
| deq_queue | output | 2 | FIFO supplying the offered descriptor |
| q_full | output | 4 | Per-FIFO full flags |
| drop_count | output | DROP_W | Count of discarded enqueues |

## Verification
Enqueues are driven just after a rising edge and are stored at the next edge. The offered descriptor is combinational from FIFO state, so it is due one edge after the enqueue. Each grant advances the output at the edge where `deq_ready` is seen high.

The bench fills the FIFOs with `deq_ready` low, hand-writes the expected drain order into a scoreboard, and then holds `deq_ready` high. The monitor compares descriptor and FIFO index at each falling edge on which a grant is offered, so each comparison lands half a cycle before the pop that consumes it.

Flags and the drop counter are sampled at the falling edge after the edge that stored the enqueue.

// File: rtl/egress_prio_sched.sv
module egress_prio_sched #(
  parameter int DESC_W = 16,
  parameter int DEPTH  = 8,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_qmode,
  input  logic              cfg_weighted,
  input  logic [1:0]        cfg_fold,
  input  logic [27:0]       cfg_weights,
  input  logic              enq_valid,
  input  logic [DESC_W-1:0] enq_desc,
  input  logic [1:0]        enq_prio,
  input  logic              deq_ready,
  output logic              deq_valid,
  output logic [DESC_W-1:0] deq_desc,
  output logic [1:0]        deq_queue,
  output logic [3:0]        q_full,
  output logic [DROP_W-1:0] drop_count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [1:0]        act_qmode, act_fold, enq_q, sel;
  logic              act_wfq, all_empty, reload, push, pop;
  logic [27:0]       act_w;
  logic [3:0]        ne, elig, cand;
  logic [CW-1:0]     cnt  [4];
  logic [AW-1:0]     wp   [4];
  logic [AW-1:0]     rp   [4];
  logic [6:0]        cred [4];
  logic [6:0]        effw [4];
  logic [6:0]        base [4];
  logic [DESC_W-1:0] mem  [4][DEPTH];

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      ne[i]     = cnt[i] != '0;
      q_full[i] = cnt[i] == CW'(DEPTH);
      effw[i]   = (act_w[7*i +: 7] == 7'd0) ? 7'd1 : act_w[7*i +: 7];
      elig[i]   = ne[i] && (cred[i] != 7'd0);
    end
  end

  assign all_empty = (ne == 4'b0000);
  assign reload    = (elig == 4'b0000);

  always_comb begin
    for (int i = 0; i < 4; i++) base[i] = reload ? effw[i] : cred[i];
  end

  always_comb begin
    case (act_qmode)
      2'b10:   enq_q = enq_prio;
      2'b01:   enq_q = {1'b0, enq_prio > act_fold};
      default: enq_q = 2'b00;
    endcase
  end

  assign cand = act_wfq ? (reload ? ne : elig) : ne;

  always_comb begin
    sel = 2'b00;
    for (int i = 0; i < 4; i++) if (cand[i]) sel = 2'(i);
  end

  assign push      = enq_valid && !q_full[enq_q];
  assign deq_valid = !all_empty;
  assign deq_queue = sel;
  assign deq_desc  = mem[sel][rp[sel]];
  assign pop       = deq_valid && deq_ready;

  always_ff @(posedge clk) begin
    if (push) mem[enq_q][wp[enq_q]] <= enq_desc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_qmode  <= 2'b00;
      act_wfq    <= 1'b0;
      act_fold   <= 2'b00;
      act_w      <= {7'd8, 7'd4, 7'd2, 7'd1};
      drop_count <= '0;
      for (int i = 0; i < 4; i++) begin
        cnt[i]  <= '0;
        wp[i]   <= '0;
        rp[i]   <= '0;
        cred[i] <= '0;
      end
    end else begin
      if (all_empty) begin
        act_qmode <= cfg_qmode;
        act_wfq   <= cfg_weighted;
        act_fold  <= cfg_fold;
        act_w     <= cfg_weights;
      end
      if (enq_valid && q_full[enq_q]) drop_count <= drop_count + 1'b1;
      for (int i = 0; i < 4; i++) begin
        if (push && enq_q == 2'(i)) wp[i] <= wp[i] + 1'b1;
        if (pop && sel == 2'(i))    rp[i] <= rp[i] + 1'b1;
        cnt[i] <= cnt[i] + CW'(push && enq_q == 2'(i)) - CW'(pop && sel == 2'(i));
        if (all_empty)
          cred[i] <= 7'd0;
        else if (pop && act_wfq)
          cred[i] <= (sel == 2'(i)) ? base[i] - 7'd1 : base[i];
      end
    end
  end
endmodule

module egress_prio_sched_chk #(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq_valid,
  input logic              deq_valid,
  input logic [1:0]        deq_queue,
  input logic [3:0]        q_full,
  input logic [DROP_W-1:0] drop_count,
  input logic [3:0]        ne,
  input logic [1:0]        act_qmode,
  input logic              act_wfq,
  input logic [27:0]       act_w
);
  // R3
  grant_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> ne[deq_queue]);

  // R5
  strict_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !act_wfq) |-> ((ne & (4'b1110 << deq_queue)) == 4'b0000));

  // R2
  single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_qmode == 2'b00 || act_qmode == 2'b11) |-> (ne[3:1] == 3'b000));

  // R6
  two_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_qmode == 2'b01) |-> (ne[3:2] == 2'b00));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |=> ($stable(act_qmode) && $stable(act_wfq) && $stable(act_w)));

  // R10
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_valid |=> $stable(drop_count));

  // R10
  full_offers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full != 4'b0000) |-> deq_valid);
endmodule

bind egress_prio_sched egress_prio_sched_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .deq_valid(deq_valid),
  .deq_queue(deq_queue), .q_full(q_full), .drop_count(drop_count), .ne(ne),
  .act_qmode(act_qmode), .act_wfq(act_wfq), .act_w(act_w)
);

// File: tb/egress_prio_sched_test.sv
module egress_prio_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_qmode = 2'b00;
  logic        cfg_weighted = 1'b0;
  logic [1:0]  cfg_fold = 2'b00;
  logic [27:0] cfg_weights = {7'd1, 7'd1, 7'd1, 7'd1};
  logic        enq_valid = 1'b0;
  logic [15:0] enq_desc = '0;
  logic [1:0]  enq_prio = '0;
  logic        deq_ready = 1'b0;
  logic        deq_valid;
  logic [15:0] deq_desc;
  logic [1:0]  deq_queue;
  logic [3:0]  q_full;
  logic [15:0] drop_count;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_d [$];
  logic [1:0]  exp_q [$];
  string       exp_t [$];

  always #2.5 clk = ~clk;

  egress_prio_sched uut (
    .clk(clk), .rst_n(rst_n), .cfg_qmode(cfg_qmode), .cfg_weighted(cfg_weighted),
    .cfg_fold(cfg_fold), .cfg_weights(cfg_weights), .enq_valid(enq_valid),
    .enq_desc(enq_desc), .enq_prio(enq_prio), .deq_ready(deq_ready),
    .deq_valid(deq_valid), .deq_desc(deq_desc), .deq_queue(deq_queue),
    .q_full(q_full), .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_out(input logic [15:0] d, input logic [1:0] q, input string tag);
    exp_d.push_back(d);
    exp_q.push_back(q);
    exp_t.push_back(tag);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic w, input logic [1:0] f,
                         input logic [27:0] wt);
    @(posedge clk); #1;
    cfg_qmode = m; cfg_weighted = w; cfg_fold = f; cfg_weights = wt;
    @(posedge clk); #1;
  endtask

  task automatic enq(input logic [1:0] p, input logic [15:0] d);
    @(posedge clk); #1;
    enq_valid = 1'b1; enq_prio = p; enq_desc = d;
    @(posedge clk); #1;
    enq_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    @(posedge clk); #1;
    deq_ready = 1'b1;
    while (exp_d.size() > 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    @(posedge clk); #1;
    deq_ready = 1'b0;
    @(negedge clk);
    check(exp_d.size() == 0, {tag, " all expected grants seen"}, exp_d.size(), 0);
    check(deq_valid == 1'b0, {tag, " R3 empty after drain"}, deq_valid, 0);
    while (exp_d.size() > 0) begin
      void'(exp_d.pop_front()); void'(exp_q.pop_front()); void'(exp_t.pop_front());
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && deq_valid && deq_ready) begin
      if (exp_d.size() == 0) begin
        check(1'b0, "unexpected grant", deq_desc, 0);
      end else begin
        logic [15:0] d;
        logic [1:0]  q;
        string       t;
        d = exp_d.pop_front();
        q = exp_q.pop_front();
        t = exp_t.pop_front();
        check(deq_desc == d, {t, " descriptor"}, deq_desc, d);
        check(deq_queue == q, {t, " queue"}, deq_queue, q);
      end
    end
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(deq_valid == 1'b0, "R1 deq_valid", deq_valid, 0);
    check(q_full == 4'b0000, "R1 q_full", q_full, 0);
    check(drop_count == 16'd0, "R1 drop_count", drop_count, 0);

    // R2 single FIFO, arrival order
    set_cfg(2'b00, 1'b0, 2'b00, {7'd1, 7'd1, 7'd1, 7'd1});
    enq(2'd3, 16'h0011); enq(2'd0, 16'h0012); enq(2'd2, 16'h0013); enq(2'd1, 16'h0014);
    @(negedge clk);
    // R3 visible right after the storing edge
    check(deq_valid == 1'b1, "R3 valid after enqueue", deq_valid, 1);
    expect_out(16'h0011, 2'd0, "R2"); expect_out(16'h0012, 2'd0, "R2");
    expect_out(16'h0013, 2'd0, "R2"); expect_out(16'h0014, 2'd0, "R2");
    drain("R2 mode00");

    // R2 reserved code 11
    set_cfg(2'b11, 1'b0, 2'b00, {7'd1, 7'd1, 7'd1, 7'd1});
    enq(2'd1, 16'h0021); enq(2'd3, 16'h0022); enq(2'd0, 16'h0023);
    expect_out(16'h0021, 2'd0, "R2 code11"); expect_out(16'h0022, 2'd0, "R2 code11");
    expect_out(16'h0023, 2'd0, "R2 code11");
    drain("R2 mode11");

    // R4 R5 four FIFOs strict
    set_cfg(2'b10, 1'b0, 2'b00, {7'd1, 7'd1, 7'd1, 7'd1});
    enq(2'd1, 16'h0101); enq(2'd3, 16'h0102); enq(2'd0, 16'h0103);
    enq(2'd3, 16'h0104); enq(2'd2, 16'h0105);
    expect_out(16'h0102, 2'd3, "R4 R5"); expect_out(16'h0104, 2'd3, "R4 R5");
    expect_out(16'h0105, 2'd2, "R4 R5"); expect_out(16'h0101, 2'd1, "R4 R5");
    expect_out(16'h0103, 2'd0, "R4 R5");
    drain("R5 strict");

    // R6 two FIFOs, fold 01: priorities 2,3 high
    set_cfg(2'b01, 1'b0, 2'b01, {7'd1, 7'd1, 7'd1, 7'd1});
    enq(2'd0, 16'h0201); enq(2'd2, 16'h0202); enq(2'd1, 16'h0203); enq(2'd3, 16'h0204);
    expect_out(16'h0202, 2'd1, "R6 fold01"); expect_out(16'h0204, 2'd1, "R6 fold01");
    expect_out(16'h0201, 2'd0, "R6 fold01"); expect_out(16'h0203, 2'd0, "R6 fold01");
    drain("R6 fold01");

    // R6 fold 00: priorities 1..3 high
    set_cfg(2'b01, 1'b0, 2'b00, {7'd1, 7'd1, 7'd1, 7'd1});
    enq(2'd0, 16'h0211); enq(2'd1, 16'h0212);
    expect_out(16'h0212, 2'd1, "R6 fold00"); expect_out(16'h0211, 2'd0, "R6 fold00");
    drain("R6 fold00");

    // R6 fold 11: all low
    set_cfg(2'b01, 1'b0, 2'b11, {7'd1, 7'd1, 7'd1, 7'd1});
    enq(2'd0, 16'h0221); enq(2'd3, 16'h0222);
    expect_out(16'h0221, 2'd0, "R6 fold11"); expect_out(16'h0222, 2'd0, "R6 fold11");
    drain("R6 fold11");

    // R7 R8 weighted: w3=2, w2=0 (acts as 1), w1=1, w0=1
    set_cfg(2'b10, 1'b1, 2'b00, {7'd2, 7'd0, 7'd1, 7'd1});
    for (int k = 0; k < 3; k++)
      for (int q = 0; q < 4; q++) enq(2'(q), 16'(16'h0300 + q * 16 + k));
    expect_out(16'h0330, 2'd3, "R7"); expect_out(16'h0331, 2'd3, "R7");
    expect_out(16'h0320, 2'd2, "R8"); expect_out(16'h0310, 2'd1, "R7");
    expect_out(16'h0300, 2'd0, "R7"); expect_out(16'h0332, 2'd3, "R7");
    expect_out(16'h0321, 2'd2, "R8"); expect_out(16'h0311, 2'd1, "R7");
    expect_out(16'h0301, 2'd0, "R7"); expect_out(16'h0322, 2'd2, "R7");
    expect_out(16'h0312, 2'd1, "R7"); expect_out(16'h0302, 2'd0, "R7");
    drain("R7 weighted");

    // R9 credits restart after idle
    enq(2'd3, 16'h0351);
    expect_out(16'h0351, 2'd3, "R9 first burst");
    drain("R9 first");
    enq(2'd3, 16'h0361); enq(2'd3, 16'h0362); enq(2'd3, 16'h0363); enq(2'd2, 16'h0364);
    expect_out(16'h0361, 2'd3, "R9"); expect_out(16'h0362, 2'd3, "R9");
    expect_out(16'h0364, 2'd2, "R9"); expect_out(16'h0363, 2'd3, "R9");
    drain("R9 second");

    // R11 change while busy is deferred
    set_cfg(2'b10, 1'b0, 2'b00, {7'd1, 7'd1, 7'd1, 7'd1});
    enq(2'd0, 16'h0401);
    @(posedge clk); #1 cfg_qmode = 2'b00;
    enq(2'd3, 16'h0402); enq(2'd0, 16'h0403);
    expect_out(16'h0402, 2'd3, "R11 old mode"); expect_out(16'h0401, 2'd0, "R11 old mode");
    expect_out(16'h0403, 2'd0, "R11 old mode");
    drain("R11 busy");
    @(posedge clk);
    enq(2'd3, 16'h0404);
    expect_out(16'h0404, 2'd0, "R11 new mode after idle");
    drain("R11 idle");

    // R10 full and drop
    for (int k = 0; k < 8; k++) enq(2'(k % 4), 16'(16'h0500 + k));
    @(negedge clk);
    check(q_full == 4'b0001, "R10 full flag", q_full, 1);
    check(drop_count == 16'd0, "R10 no drop yet", drop_count, 0);
    enq(2'd2, 16'h05FF);
    @(negedge clk);
    check(drop_count == 16'd1, "R10 drop counted", drop_count, 1);
    check(q_full == 4'b0001, "R10 still full", q_full, 1);
    for (int k = 0; k < 8; k++) expect_out(16'(16'h0500 + k), 2'd0, "R10 kept entries");
    drain("R10 drain");
    @(negedge clk);
    check(q_full == 4'b0000, "R10 full clears", q_full, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule